// File: doc/BRIEF.md
# Command, Status and Interrupt Register Block

This block is the small register file that software uses to drive a network controller's command and receive engines. It sits on a byte-addressed register bus with 32-bit data and per-byte enables. The first dword holds four byte registers. A status word reports the engines' current state and a set of latched interrupt causes. An acknowledge byte clears causes when 1s are written to it. A command byte carries one opcode for the command engine and one for the receive engine. An interrupt control byte holds a mask and a software-interrupt trigger. The second dword is a general 32-bit pointer.

The engines report events and their unit state on input pins. When the engines are ready, a pending command is handed over as a one-cycle strobe. The strobe carries both decoded opcodes and the pointer. The command byte then returns to zero. Software polls the command byte for zero before it writes the next command. The interrupt output is a level signal.

Top module: `nic_cs_regs`

## Requirements
- R1: After reset, every status cause bit, the command byte, the mask bit, the pointer, `irqOut` and `cmdStrobe` are all zero.
- R2: Status bits 7:6 show `cuState` and bits 5:2 show `ruState`. Bits 1:0 and 9:8 read zero. A write to byte offset 0 has no effect.
- R3: A 1 on `causeEvt[i]` sets status bit 10+i, and the bit stays set until it is acknowledged. The mapping is: i=0 software interrupt, 1 management access done, 2 receive unit not ready, 3 command unit left active, 4 frame received, 5 command executed.
- R4: A byte written to offset 1 clears every cause bit whose position (status bit 8+k for data bit k) holds a 1. Positions written as 0 are left unchanged.
- R5: If a cause event and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R6: `irqOut` is high exactly when at least one cause bit is set and the mask (offset 3, bit 0) is clear.
- R7: Writing 1 to offset 3 bit 1 sets the software interrupt cause (status bit 10). That bit reads 0. Bit 0 reads back the mask.
- R8: A nonzero byte written to offset 2 while it reads zero is held and read back until it is accepted. A write while it is nonzero is ignored. A write of zero leaves it zero and issues nothing.
- R9: When the command byte is nonzero and `engReady` is high at a clock edge, `cmdStrobe` is high for exactly the following cycle. The command byte reads zero from the cycle after that.
- R10: During the strobe, `cuCmd` carries the upper nibble of the command and `ruCmd` the lower nibble. A nibble not in {1,2,4,5,6,7} is reported as 0.
- R11: During the strobe, `cmdPtr` equals the pointer value.
- R12: The pointer at offset 4 is read/write, and each of its bytes is written only when its byte enable is set.
- R13: One bus access with several byte enables set updates each enabled register of the dword, for example command and interrupt control together in one 16-bit write at offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address; the dword is selected by bits above 1 |
| busByteEn | input | 4 | Byte lane enables |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed dword (combinational) |
| causeEvt | input | 6 | One-cycle cause event pulses from the engines |
| cuState | input | 2 | Command unit state: 0 idle, 1 suspended, 2 active |
| ruState | input | 4 | Receive unit state: 0 idle, 1 suspended, 2 no resources, 4 ready |
| engReady | input | 1 | Engines can accept a command |
| cmdStrobe | output | 1 | One-cycle command hand-over |
| cuCmd | output | 4 | Decoded command unit opcode |
| ruCmd | output | 4 | Decoded receive unit opcode |
| cmdPtr | output | 32 | Pointer value captured with the command |
| irqOut | output | 1 | Interrupt request level |

## Verification
A register write or a cause event is taken at the clock edge. Its effect shows on `busRdData` and `irqOut` in the cycle after that edge, because both are combinational from the registers. A pending command with `engReady` high produces the strobe one edge later. The command byte reads zero one edge after the strobe. The bench drives inputs on the falling edge and samples at the next falling edge, so each check falls exactly in the cycle named above. The command handshake is checked cycle by cycle across all 256 command bytes.

// File: rtl/nic_cs_pkg.sv
package nic_cs_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CAUSE = 6;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = 4;

  typedef struct packed {
    logic [BYTE_W-1:0]  ackMask;
    logic               cmdWr;
    logic [BYTE_W-1:0]  cmdData;
    logic               cmdClr;
    logic               intCtlWr;
    logic               maskVal;
    logic               swiSet;
    logic [3:0]         ptrBe;
    logic [DATA_W-1:0]  ptrData;
  } csStrobe_t;

  function automatic logic [NIB_W-1:0] decodeNib(input logic [NIB_W-1:0] n);
    logic ok;
    ok = (n == 4'd1) || (n == 4'd2) || (n == 4'd4) ||
         (n == 4'd5) || (n == 4'd6) || (n == 4'd7);
    return ok ? n : '0;
  endfunction
endpackage

// File: rtl/nic_cs_datapath.sv
module nic_cs_datapath
  import nic_cs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  csStrobe_t            strb,
  input  logic [NUM_CAUSE-1:0] causeEvt,
  input  logic [1:0]           cuState,
  input  logic [3:0]           ruState,
  output logic [DATA_W-1:0]    ctlWord,
  output logic [DATA_W-1:0]    ptrVal,
  output logic                 cmdPending,
  output logic [BYTE_W-1:0]    cmdByte,
  output logic                 irqOut
);
  logic [NUM_CAUSE-1:0] causes;
  logic [NUM_CAUSE-1:0] setVec;
  logic [NUM_CAUSE-1:0] clrVec;
  logic                 maskQ;
  logic [BYTE_W-1:0]    cmdReg;
  logic [DATA_W-1:0]    ptrReg;

  always_comb begin
    setVec = causeEvt;
    setVec[0] = causeEvt[0] | strb.swiSet;
    clrVec = strb.ackMask[BYTE_W-1:BYTE_W-NUM_CAUSE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) causes <= '0;
    else       causes <= (causes & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              maskQ <= 1'b0;
    else if (strb.intCtlWr) maskQ <= strb.maskVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            cmdReg <= '0;
    else if (strb.cmdClr)                 cmdReg <= '0;
    else if (strb.cmdWr && cmdReg == '0)  cmdReg <= strb.cmdData;
  end

  for (genvar b = 0; b < DATA_W/BYTE_W; b++) begin : g_ptrByte
    always_ff @(posedge clk) begin
      if (!rstN)               ptrReg[b*BYTE_W +: BYTE_W] <= '0;
      else if (strb.ptrBe[b])  ptrReg[b*BYTE_W +: BYTE_W] <= strb.ptrData[b*BYTE_W +: BYTE_W];
    end
  end

  assign ctlWord    = {7'b0, maskQ, cmdReg, causes, 2'b00, cuState, ruState, 2'b00};
  assign ptrVal     = ptrReg;
  assign cmdPending = (cmdReg != '0);
  assign cmdByte    = cmdReg;
  assign irqOut     = (causes != '0) && !maskQ;

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (causeEvt != '0) |=> ((causes & $past(causeEvt)) == $past(causeEvt)));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~setVec) != '0) |=> ((causes & $past(clrVec & ~setVec)) == '0));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & setVec) != '0) |=> ((causes & $past(clrVec & setVec)) == $past(clrVec & setVec)));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg != '0 && !strb.cmdClr) |=> (cmdReg == $past(cmdReg)));
endmodule

// File: rtl/nic_cs_ctrl.sv
module nic_cs_ctrl
  import nic_cs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              cmdPending,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic [DATA_W-1:0] ptrVal,
  input  logic              engReady,
  output csStrobe_t         strb,
  output logic              selCtl,
  output logic              selPtr,
  output logic              cmdStrobe,
  output logic [NIB_W-1:0]  cuCmd,
  output logic [NIB_W-1:0]  ruCmd,
  output logic [DATA_W-1:0] cmdPtr
);
  localparam int DW_IDX_W = ADDR_W;

  typedef enum logic {HS_WAIT, HS_ISSUE} hsState_t;

  logic [DW_IDX_W-1:0] dwIdx;
  hsState_t            hsQ;
  logic [NIB_W-1:0]    cuQ, ruQ;
  logic [DATA_W-1:0]   ptrQ;

  assign dwIdx  = busAddr >> 2;
  assign selCtl = (dwIdx == DW_IDX_W'(0));
  assign selPtr = (dwIdx == DW_IDX_W'(1));

  always_comb begin
    strb          = '0;
    strb.ptrData  = busWrData;
    strb.cmdData  = busWrData[23:16];
    strb.maskVal  = busWrData[24];
    strb.cmdClr   = (hsQ == HS_ISSUE);
    if (busWrEn && selCtl) begin
      if (busByteEn[1]) strb.ackMask = busWrData[15:8];
      strb.cmdWr    = busByteEn[2];
      strb.intCtlWr = busByteEn[3];
      strb.swiSet   = busByteEn[3] & busWrData[25];
    end
    if (busWrEn && selPtr) strb.ptrBe = busByteEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsQ  <= HS_WAIT;
      cuQ  <= '0;
      ruQ  <= '0;
      ptrQ <= '0;
    end else begin
      case (hsQ)
        HS_WAIT: if (cmdPending && engReady) begin
          hsQ  <= HS_ISSUE;
          cuQ  <= decodeNib(cmdByte[7:4]);
          ruQ  <= decodeNib(cmdByte[3:0]);
          ptrQ <= ptrVal;
        end
        default: hsQ <= HS_WAIT;
      endcase
    end
  end

  assign cmdStrobe = (hsQ == HS_ISSUE);
  assign cuCmd     = cuQ;
  assign ruCmd     = ruQ;
  assign cmdPtr    = ptrQ;

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R9
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdStrobe) |-> $past(cmdPending && engReady));

  // R9
  clear_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdPending);
endmodule

// File: rtl/nic_cs_regs.sv
module nic_cs_regs
  import nic_cs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [3:0]           busByteEn,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_CAUSE-1:0] causeEvt,
  input  logic [1:0]           cuState,
  input  logic [3:0]           ruState,
  input  logic                 engReady,
  output logic                 cmdStrobe,
  output logic [NIB_W-1:0]     cuCmd,
  output logic [NIB_W-1:0]     ruCmd,
  output logic [DATA_W-1:0]    cmdPtr,
  output logic                 irqOut
);
  csStrobe_t         strb;
  logic              selCtl, selPtr, cmdPending;
  logic [BYTE_W-1:0] cmdByte;
  logic [DATA_W-1:0] ctlWord, ptrVal;

  nic_cs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrEn(busWrEn), .busWrData(busWrData), .cmdPending(cmdPending),
    .cmdByte(cmdByte), .ptrVal(ptrVal), .engReady(engReady), .strb(strb),
    .selCtl(selCtl), .selPtr(selPtr), .cmdStrobe(cmdStrobe),
    .cuCmd(cuCmd), .ruCmd(ruCmd), .cmdPtr(cmdPtr)
  );

  nic_cs_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .causeEvt(causeEvt),
    .cuState(cuState), .ruState(ruState), .ctlWord(ctlWord),
    .ptrVal(ptrVal), .cmdPending(cmdPending), .cmdByte(cmdByte),
    .irqOut(irqOut)
  );

  always_comb begin
    busRdData = '0;
    if (selCtl)      busRdData = ctlWord;
    else if (selPtr) busRdData = ptrVal;
  end
endmodule

// File: tb/nic_cs_regs_bench.sv
module nic_cs_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  causeEvt = '0;
  logic [1:0]  cuState = '0;
  logic [3:0]  ruState = '0;
  logic        engReady = 1'b0;
  logic        cmdStrobe;
  logic [3:0]  cuCmd, ruCmd;
  logic [31:0] cmdPtr;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_cs_regs u_nic_cs_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .causeEvt(causeEvt), .cuState(cuState), .ruState(ruState),
    .engReady(engReady), .cmdStrobe(cmdStrobe), .cuCmd(cuCmd),
    .ruCmd(ruCmd), .cmdPtr(cmdPtr), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    busAddr = a; busByteEn = be; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busByteEn = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  function automatic logic [3:0] decNib(input logic [3:0] n);
    return (n inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7}) ? n : 4'd0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  exp;
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    rd(3'd0, d); check("R1 ctl dword", d, 32'h0);
    rd(3'd4, d); check("R1 pointer", d, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 strobe", {31'b0, cmdStrobe}, 32'h0);

    // R2 unit state fields
    foreach (d[k]) begin end
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < 4; r++) begin
        cuState = 2'(c); ruState = (r == 3) ? 4'd4 : 4'(r);
        #1; rd(3'd0, d);
        check("R2 state bits", {24'b0, d[7:0]}, {24'b0, 2'(c), ruState, 2'b00});
      end
    end
    cuState = 2'd2; ruState = 4'd4;
    wr(3'd0, 4'b0001, 32'hFF);
    rd(3'd0, d); check("R2 status low write ignored", {24'b0, d[7:0]}, 32'h90);

    // R3 each event sets its bit and holds
    for (int i = 0; i < 6; i++) begin
      wr(3'd1, 4'b0010, 32'hFF00);
      causeEvt = 6'(1 << i); tick(); causeEvt = '0; tick();
      rd(3'd0, d); check("R3 event bit", {16'b0, d[15:8]}, 32'(1 << (i + 2)));
      check("R6 irq on cause", {31'b0, irqOut}, 32'h1);
    end

    // R4 acknowledge sweep over all byte values
    for (int a = 0; a < 256; a++) begin
      causeEvt = 6'h3F; tick(); causeEvt = '0;
      wr(3'd1, 4'b0010, 32'(a) << 8);
      exp = 6'h3F & ~6'(a >> 2);
      rd(3'd0, d); check("R4 ack clear", {24'b0, d[15:8]}, {24'b0, exp, 2'b00});
      check("R6 irq after ack", {31'b0, irqOut}, {31'b0, exp != 0});
    end

    // R5 event and acknowledge in the same cycle
    for (int i = 0; i < 6; i++) begin
      wr(3'd1, 4'b0010, 32'hFF00);
      busAddr = 3'd1; busByteEn = 4'b0010; busWrData = 32'hFF00; busWrEn = 1'b1;
      causeEvt = 6'(1 << i); tick();
      busWrEn = 1'b0; busByteEn = '0; causeEvt = '0;
      rd(3'd0, d); check("R5 event wins", {16'b0, d[15:8]}, 32'(1 << (i + 2)));
    end

    // R6 mask
    wr(3'd3, 4'b1000, 32'h0100);
    wr(3'd3, 4'b1000, 32'h0100_0000);
    check("R6 masked", {31'b0, irqOut}, 32'h0);
    rd(3'd0, d); check("R7 mask readback", {24'b0, d[31:24]}, 32'h1);
    wr(3'd3, 4'b1000, 32'h0);
    check("R6 unmasked", {31'b0, irqOut}, 32'h1);

    // R7 software interrupt
    wr(3'd1, 4'b0010, 32'hFF00);
    check("R6 no cause", {31'b0, irqOut}, 32'h0);
    wr(3'd3, 4'b1000, 32'h0200_0000);
    rd(3'd0, d);
    check("R7 swi cause", {24'b0, d[15:8]}, 32'h04);
    check("R7 bit1 reads 0", {24'b0, d[31:24]}, 32'h0);
    wr(3'd1, 4'b0010, 32'hFF00);

    // R12 pointer byte enables
    wr(3'd4, 4'b1111, 32'hA5C3_1E07);
    rd(3'd4, d); check("R12 pointer full", d, 32'hA5C3_1E07);
    wr(3'd4, 4'b0101, 32'h1122_3344);
    rd(3'd4, d); check("R12 pointer lanes", d, 32'hA522_1E44);

    // R13 16-bit access at offset 2
    wr(3'd2, 4'b1100, 32'h0133_0000);
    rd(3'd0, d);
    check("R13 cmd lane", {24'b0, d[23:16]}, 32'h33);
    check("R13 intctl lane", {24'b0, d[31:24]}, 32'h1);
    engReady = 1'b1; tick(); tick(); engReady = 1'b0;
    wr(3'd3, 4'b1000, 32'h0);

    // R8-R11 full command sweep
    for (int c = 0; c < 256; c++) begin
      engReady = 1'b0;
      wr(3'd2, 4'b0100, 32'(c) << 16);
      rd(3'd0, d); check("R8 cmd readback", {24'b0, d[23:16]}, 32'(c));
      if (c == 0) begin
        engReady = 1'b1;
        tick(); check("R8 zero no strobe", {31'b0, cmdStrobe}, 32'h0);
        tick(); check("R8 zero no strobe", {31'b0, cmdStrobe}, 32'h0);
      end else begin
        wr(3'd2, 4'b0100, 32'h00EE_0000);
        rd(3'd0, d); check("R8 write while pending", {24'b0, d[23:16]}, 32'(c));
        check("R9 no strobe when not ready", {31'b0, cmdStrobe}, 32'h0);
        engReady = 1'b1;
        tick();
        check("R9 strobe", {31'b0, cmdStrobe}, 32'h1);
        check("R10 cu opcode", {28'b0, cuCmd}, {28'b0, decNib(4'(c >> 4))});
        check("R10 ru opcode", {28'b0, ruCmd}, {28'b0, decNib(4'(c))});
        check("R11 pointer", cmdPtr, 32'hA522_1E44);
        rd(3'd0, d); check("R9 pending during strobe", {24'b0, d[23:16]}, 32'(c));
        tick();
        check("R9 strobe single", {31'b0, cmdStrobe}, 32'h0);
        rd(3'd0, d); check("R9 cleared", {24'b0, d[23:16]}, 32'h0);
      end
    end
    engReady = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule